// File: doc/BRIEF.md
# Enhanced Min-Sum Check-Node Unit

This block is the check-node half of a layered min-sum decoder for low-density parity-check codes. It takes the variable-to-check messages of one parity-check row serially, one message per clock cycle. While the row streams in, it keeps four running quantities: the smallest magnitude, the second-smallest magnitude, the position of the smallest, and the XOR of all input signs. Only these quantities and one sign bit per position are held, so the row result stays in compressed form.

When the last message of a row has been taken, the compressed result is copied into an output bank. An emission phase then sends one check-to-variable message per cycle, one for each position of the row. Each outgoing magnitude is the chosen minimum scaled by three quarters. An enhancement step sits on top of that scaled min-sum value. If the two minima are close, meaning the gap between them is at or below a programmable threshold, the inputs are treated as unreliable and every outgoing magnitude gets one extra LSB. The output bank is separate from the trackers, so the next row can stream in while the previous row is being emitted.

The tracker has two states. `TRK_IDLE` waits with no open row. `TRK_OPEN` collects a row that is in progress. Transitions: open (`TRK_IDLE` to `TRK_OPEN` on an accepted first message that is not also the last), close (`TRK_OPEN` to `TRK_IDLE` on an accepted last message), single (a first-and-last message stays in `TRK_IDLE` and closes the row at once) and restart (a first message in `TRK_OPEN` drops the open row and stays in `TRK_OPEN`). The emitter also has two states. `EMT_IDLE` sends nothing and `EMT_SEND` emits positions. Transitions: load (any state to `EMT_SEND` when a row closes), finish (`EMT_SEND` to `EMT_IDLE` after the final position) and step (`EMT_SEND` to itself, advancing the position).

Top module: `ems_check_unit`

## Requirements
- R1: `in_msg` is sign-magnitude: bit 5 is the sign (1 = negative) and bits 4:0 are the magnitude. A message is taken when `in_valid` is high and either `in_first` is high or a row is open. `in_valid` with no open row and no `in_first` is ignored and starts no emission.
- R2: Within a row, a magnitude strictly below the current minimum becomes the minimum, and its position (0 for the first message of the row) becomes `cmp_idx`. The old minimum becomes the second minimum. Otherwise a magnitude strictly below the second minimum replaces the second minimum. On equal magnitudes the earlier position keeps the minimum. Both trackers start at 31, so a one-message row reports `cmp_min2` = 31.
- R3: `cmp_sign` is the XOR of the sign bits of all messages in the row.
- R4: The scaled value of a magnitude m is floor(m/2) + floor(m/4).
- R5: `cmp_boost` is 1 exactly when `cmp_min2 - cmp_min <= boost_thr`, with `boost_thr` sampled in the cycle the last message is taken. When it is 1, one is added to every outgoing scaled magnitude, and the result never exceeds 31.
- R6: The outgoing message for position p has magnitude built from `cmp_min2` when p equals `cmp_idx` and from `cmp_min` otherwise. Its sign bit (bit 5) is `cmp_sign` XOR the sign of input p.
- R7: Emission of a row of degree d starts in the cycle after the clock edge that takes its last message. `out_valid` is then high for d consecutive cycles with `out_pos` = 0 to d-1. `out_last` is high only on position d-1, and `out_valid` drops afterwards unless another row has closed.
- R8: After reset, `out_valid` and `out_last` are low and no row is open.
- R9: A message with `in_first` while a row is open discards that row, and the message becomes position 0 of a new row.
- R10: The compressed outputs stay constant during an emission, even while the next row is being collected. A row that closes on the edge of the final position starts its emission with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message present |
| in_first | input | 1 | Message is position 0 of a new row |
| in_last | input | 1 | Message is the final one of the row |
| in_msg | input | 6 | Variable-to-check message, sign-magnitude |
| boost_thr | input | 5 | Largest minima gap that triggers the boost |
| out_valid | output | 1 | Check-to-variable message present |
| out_last | output | 1 | Final position of the emitted row |
| out_pos | output | 3 | Position of the emitted message |
| out_msg | output | 6 | Check-to-variable message, sign-magnitude |
| cmp_min | output | 5 | Compressed result: smallest magnitude |
| cmp_min2 | output | 5 | Compressed result: second-smallest magnitude |
| cmp_idx | output | 3 | Compressed result: position of the smallest |
| cmp_sign | output | 1 | Compressed result: sign product |
| cmp_boost | output | 1 | Compressed result: enhancement decision |

## Verification
The assertions assume the upstream never closes a new row while an emission has positions still to send, except on the edge that emits the final position. They also assume a row never holds more than eight messages. Both are needed for the step-by-one position and constant-result properties. The bench keeps to both. It waits for each emission to finish before closing another row, and its one overlapping case feeds an eight-message row alongside an eight-position emission, so the new row closes exactly on the final position. Row degrees in the sweep run from one to eight.

// File: rtl/ems_cnu_pkg.sv
package ems_cnu_pkg;

    typedef enum logic {
        TRK_IDLE,
        TRK_OPEN
    } trk_state_t;

    typedef enum logic {
        EMT_IDLE,
        EMT_SEND
    } emt_state_t;

endpackage

// File: rtl/ems_cnu_tracker.sv
module ems_cnu_tracker
    import ems_cnu_pkg::*;
#(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 8,
    localparam int MAGW   = MSG_W - 1,
    localparam int IW     = $clog2(MAX_DEG),
    localparam int DW     = $clog2(MAX_DEG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [MSG_W-1:0]   in_msg,
    output logic               row_done,
    output logic [MAGW-1:0]    nx_min,
    output logic [MAGW-1:0]    nx_min2,
    output logic [IW-1:0]      nx_idx,
    output logic               nx_sign,
    output logic [MAX_DEG-1:0] nx_signs,
    output logic [DW-1:0]      nx_deg
);

    localparam logic [MAGW-1:0] MAGMAX = {MAGW{1'b1}};

    trk_state_t st_q, st_nx;

    logic [MAGW-1:0]    min_q, min2_q;
    logic [IW-1:0]      idx_q;
    logic               sp_q;
    logic [MAX_DEG-1:0] signs_q;
    logic [DW-1:0]      cnt_q;

    logic               accept;
    logic [MAGW-1:0]    b_min, b_min2, mag;
    logic [IW-1:0]      b_idx, pos;
    logic               b_sp, sgn;
    logic [MAX_DEG-1:0] b_signs;
    logic [DW-1:0]      b_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_IDLE;
        else        st_q <= st_nx;
    end

    // next state and tracker values
    always_comb begin
        accept  = in_valid && (in_first || st_q == TRK_OPEN);
        row_done = accept && in_last;

        b_min   = in_first ? MAGMAX : min_q;
        b_min2  = in_first ? MAGMAX : min2_q;
        b_idx   = in_first ? '0 : idx_q;
        b_sp    = in_first ? 1'b0 : sp_q;
        b_signs = in_first ? '0 : signs_q;
        b_cnt   = in_first ? '0 : cnt_q;

        mag = in_msg[MAGW-1:0];
        sgn = in_msg[MSG_W-1];
        pos = b_cnt[IW-1:0];

        nx_min  = b_min;
        nx_min2 = b_min2;
        nx_idx  = b_idx;
        if (mag < b_min) begin
            nx_min  = mag;
            nx_min2 = b_min;
            nx_idx  = pos;
        end else if (mag < b_min2) begin
            nx_min2 = mag;
        end
        nx_sign       = b_sp ^ sgn;
        nx_signs      = b_signs;
        nx_signs[pos] = sgn;
        nx_deg        = b_cnt + DW'(1);

        st_nx = st_q;
        unique case (st_q)
            TRK_IDLE: if (accept && !in_last) st_nx = TRK_OPEN;
            TRK_OPEN: if (accept && in_last)  st_nx = TRK_IDLE;
        endcase
    end

    // tracker registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q   <= MAGMAX;
            min2_q  <= MAGMAX;
            idx_q   <= '0;
            sp_q    <= 1'b0;
            signs_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            min_q   <= nx_min;
            min2_q  <= nx_min2;
            idx_q   <= nx_idx;
            sp_q    <= nx_sign;
            signs_q <= nx_signs;
            cnt_q   <= nx_deg;
        end
    end

endmodule

// File: rtl/ems_cnu_magxf.sv
module ems_cnu_magxf #(
    parameter int MAGW = 5
) (
    input  logic [MAGW-1:0] mag,
    input  logic            boost,
    output logic [MAGW-1:0] res
);

    localparam logic [MAGW:0] SATV = {1'b0, {MAGW{1'b1}}};

    logic [MAGW:0] sum;

    // three-quarter scaling by shift and add, optional one-LSB boost
    always_comb begin
        sum = (MAGW+1)'(mag >> 1) + (MAGW+1)'(mag >> 2) + (MAGW+1)'(boost);
        res = (sum > SATV) ? SATV[MAGW-1:0] : sum[MAGW-1:0];
    end

endmodule

// File: rtl/ems_cnu_emitter.sv
module ems_cnu_emitter
    import ems_cnu_pkg::*;
#(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 8,
    localparam int MAGW   = MSG_W - 1,
    localparam int IW     = $clog2(MAX_DEG),
    localparam int DW     = $clog2(MAX_DEG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               row_done,
    input  logic [MAGW-1:0]    ld_min,
    input  logic [MAGW-1:0]    ld_min2,
    input  logic [IW-1:0]      ld_idx,
    input  logic               ld_sign,
    input  logic [MAX_DEG-1:0] ld_signs,
    input  logic [DW-1:0]      ld_deg,
    input  logic [MAGW-1:0]    boost_thr,
    output logic               out_valid,
    output logic               out_last,
    output logic [IW-1:0]      out_pos,
    output logic [MSG_W-1:0]   out_msg,
    output logic [MAGW-1:0]    cmp_min,
    output logic [MAGW-1:0]    cmp_min2,
    output logic [IW-1:0]      cmp_idx,
    output logic               cmp_sign,
    output logic               cmp_boost
);

    emt_state_t st_q, st_nx;

    logic [MAGW-1:0]    min_q, min2_q;
    logic [IW-1:0]      idx_q, pos_q;
    logic               sp_q, boost_q;
    logic [MAX_DEG-1:0] signs_q;
    logic [DW-1:0]      deg_q;
    logic               at_end;

    logic [MAGW-1:0] xf_src [2];
    logic [MAGW-1:0] xf_res [2];

    assign xf_src[0] = min_q;
    assign xf_src[1] = min2_q;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_xf
            ems_cnu_magxf #(.MAGW(MAGW)) i_xf (
                .mag   (xf_src[g]),
                .boost (boost_q),
                .res   (xf_res[g])
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EMT_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        at_end = (DW'(pos_q) + DW'(1)) == deg_q;
        st_nx  = st_q;
        unique case (st_q)
            EMT_IDLE: if (row_done) st_nx = EMT_SEND;
            EMT_SEND: if (!row_done && at_end) st_nx = EMT_IDLE;
        endcase
    end

    // output bank and position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q   <= '1;
            min2_q  <= '1;
            idx_q   <= '0;
            sp_q    <= 1'b0;
            boost_q <= 1'b0;
            signs_q <= '0;
            deg_q   <= '0;
            pos_q   <= '0;
        end else if (row_done) begin
            min_q   <= ld_min;
            min2_q  <= ld_min2;
            idx_q   <= ld_idx;
            sp_q    <= ld_sign;
            boost_q <= (ld_min2 - ld_min) <= boost_thr;
            signs_q <= ld_signs;
            deg_q   <= ld_deg;
            pos_q   <= '0;
        end else if (st_q == EMT_SEND) begin
            pos_q   <= pos_q + IW'(1);
        end
    end

    // outputs
    always_comb begin
        out_valid = (st_q == EMT_SEND);
        out_last  = out_valid && at_end;
        out_pos   = pos_q;
        out_msg   = {sp_q ^ signs_q[pos_q], (pos_q == idx_q) ? xf_res[1] : xf_res[0]};
        cmp_min   = min_q;
        cmp_min2  = min2_q;
        cmp_idx   = idx_q;
        cmp_sign  = sp_q;
        cmp_boost = boost_q;
    end

endmodule

// File: rtl/ems_check_unit.sv
module ems_check_unit #(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_first,
    input  logic                         in_last,
    input  logic [MSG_W-1:0]             in_msg,
    input  logic [MSG_W-2:0]             boost_thr,
    output logic                         out_valid,
    output logic                         out_last,
    output logic [$clog2(MAX_DEG)-1:0]   out_pos,
    output logic [MSG_W-1:0]             out_msg,
    output logic [MSG_W-2:0]             cmp_min,
    output logic [MSG_W-2:0]             cmp_min2,
    output logic [$clog2(MAX_DEG)-1:0]   cmp_idx,
    output logic                         cmp_sign,
    output logic                         cmp_boost
);

    localparam int MAGW = MSG_W - 1;
    localparam int IW   = $clog2(MAX_DEG);
    localparam int DW   = $clog2(MAX_DEG + 1);

    logic               row_done;
    logic [MAGW-1:0]    nx_min, nx_min2;
    logic [IW-1:0]      nx_idx;
    logic               nx_sign;
    logic [MAX_DEG-1:0] nx_signs;
    logic [DW-1:0]      nx_deg;

    ems_cnu_tracker #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG)) i_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_last  (in_last),
        .in_msg   (in_msg),
        .row_done (row_done),
        .nx_min   (nx_min),
        .nx_min2  (nx_min2),
        .nx_idx   (nx_idx),
        .nx_sign  (nx_sign),
        .nx_signs (nx_signs),
        .nx_deg   (nx_deg)
    );

    ems_cnu_emitter #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG)) i_emt (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_done  (row_done),
        .ld_min    (nx_min),
        .ld_min2   (nx_min2),
        .ld_idx    (nx_idx),
        .ld_sign   (nx_sign),
        .ld_signs  (nx_signs),
        .ld_deg    (nx_deg),
        .boost_thr (boost_thr),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_pos   (out_pos),
        .out_msg   (out_msg),
        .cmp_min   (cmp_min),
        .cmp_min2  (cmp_min2),
        .cmp_idx   (cmp_idx),
        .cmp_sign  (cmp_sign),
        .cmp_boost (cmp_boost)
    );

endmodule

// File: rtl/ems_check_unit_chk.sv
module ems_check_unit_chk #(
    parameter int MSG_W   = 6,
    parameter int MAX_DEG = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       out_valid,
    input logic                       out_last,
    input logic [$clog2(MAX_DEG)-1:0] out_pos,
    input logic [MSG_W-2:0]           out_mag,
    input logic [MSG_W-2:0]           cmp_min,
    input logic [MSG_W-2:0]           cmp_min2,
    input logic [$clog2(MAX_DEG)-1:0] cmp_idx,
    input logic                       cmp_sign,
    input logic                       cmp_boost
);

    localparam int IW = $clog2(MAX_DEG);

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R7
    emit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid && (out_pos == IW'($past(out_pos) + 1'b1)));

    // R7
    last_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2
    min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cmp_min <= cmp_min2);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> $stable(cmp_min) && $stable(cmp_min2)
            && $stable(cmp_idx) && $stable(cmp_sign) && $stable(cmp_boost));

    // R6
    plain_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_pos != cmp_idx) && !cmp_boost |-> out_mag <= cmp_min);

    // R5
    boost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cmp_boost |-> out_mag != '0);

endmodule

bind ems_check_unit ems_check_unit_chk #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_pos   (out_pos),
    .out_mag   (out_msg[MSG_W-2:0]),
    .cmp_min   (cmp_min),
    .cmp_min2  (cmp_min2),
    .cmp_idx   (cmp_idx),
    .cmp_sign  (cmp_sign),
    .cmp_boost (cmp_boost)
);

// File: tb/test_ems_check_unit.sv
`timescale 1ns/1ps
module test_ems_check_unit;

    typedef int row_t [8];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [5:0] in_msg = '0;
    logic [4:0] boost_thr = '0;
    logic       out_valid, out_last, cmp_sign, cmp_boost;
    logic [2:0] out_pos, cmp_idx;
    logic [5:0] out_msg;
    logic [4:0] cmp_min, cmp_min2;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    ems_check_unit i_ems_check_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_msg(in_msg), .boost_thr(boost_thr),
        .out_valid(out_valid), .out_last(out_last), .out_pos(out_pos),
        .out_msg(out_msg), .cmp_min(cmp_min), .cmp_min2(cmp_min2),
        .cmp_idx(cmp_idx), .cmp_sign(cmp_sign), .cmp_boost(cmp_boost)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int xf(input int m, input int b);
        int v = m / 2 + m / 4 + b;
        return (v > 31) ? 31 : v;
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) & 32'h3f);
    endfunction

    task automatic send_row(input row_t m, input int deg, input int thr);
        boost_thr = 5'(thr);
        for (int k = 0; k < deg; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = (k == deg - 1);
            in_msg   = 6'(m[k]);
        end
    endtask

    // checks one emitted row; optionally feeds the next row alongside
    task automatic check_emit(input row_t m, input int deg, input int thr,
                              input bit chain, input row_t n);
        int emin = 31, emin2 = 31, eidx = 0, esp = 0, eb, mg, sel;
        for (int k = 0; k < deg; k++) begin
            mg = m[k] & 31;
            if (mg < emin) begin emin2 = emin; emin = mg; eidx = k; end
            else if (mg < emin2) emin2 = mg;
            esp ^= (m[k] >> 5) & 1;
        end
        eb = ((emin2 - emin) <= thr) ? 1 : 0;
        @(negedge clk);
        for (int p = 0; p < deg; p++) begin
            if (p > 0) @(negedge clk);
            if (chain) begin
                in_valid = 1'b1;
                in_first = (p == 0);
                in_last  = (p == 7);
                in_msg   = 6'(n[p]);
            end else begin
                in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
            end
            sel = (p == eidx) ? emin2 : emin;
            chk("R7 valid", int'(out_valid), 1);
            chk("R7 pos", int'(out_pos), p);
            chk("R7 last", int'(out_last), (p == deg - 1) ? 1 : 0);
            chk("R2 min", int'(cmp_min), emin);
            chk("R2 min2", int'(cmp_min2), emin2);
            chk("R2 idx", int'(cmp_idx), eidx);
            chk("R3 sign product", int'(cmp_sign), esp);
            chk("R5 boost flag", int'(cmp_boost), eb);
            chk("R4 R6 magnitude", int'(out_msg[4:0]), xf(sel, eb));
            chk("R6 sign", int'(out_msg[5]), esp ^ ((m[p] >> 5) & 1));
        end
        if (!chain) begin
            @(negedge clk);
            in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
            chk("R7 emission stops", int'(out_valid), 0);
        end
    endtask

    task automatic run_row(input row_t m, input int deg, input int thr);
        row_t z = '{default: 0};
        send_row(m, deg, thr);
        check_emit(m, deg, thr, 1'b0, z);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        row_t a, b, z;
        z = '{default: 0};
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 out_valid", int'(out_valid), 0);
        chk("R8 out_last", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle after release", int'(out_valid), 0);

        // R1: valid without an open row or first flag is ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_msg = 6'd3;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R1 stray input ignored", int'(out_valid), 0);
            @(negedge clk);
        end

        // R2 single-message row, min2 stays 31
        a = '{6'd37, 0, 0, 0, 0, 0, 0, 0};
        run_row(a, 1, 0);
        // R2 ties: earlier position keeps minimum
        a = '{9, 9, 41, 9, 20, 0, 0, 0};
        run_row(a, 5, 0);
        // R5 threshold boundary: gap 4 with thr 4 boosts, thr 3 does not
        a = '{14, 10, 50, 30, 0, 0, 0, 0};
        run_row(a, 4, 4);
        run_row(a, 4, 3);
        // R4 largest magnitudes
        a = '{31, 63, 31, 63, 31, 63, 31, 63};
        run_row(a, 8, 0);
        a = '{0, 32, 63, 1, 2, 33, 40, 7};
        run_row(a, 8, 31);

        // R9: first flag mid-row restarts
        boost_thr = 5'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = (k == 0); in_last = 1'b0; in_msg = 6'd1;
        end
        a = '{20, 52, 18, 25, 0, 0, 0, 0};
        run_row(a, 4, 2);

        // R10: next row collected during emission, closes on final position
        for (int k = 0; k < 8; k++) begin a[k] = rnd(); b[k] = rnd(); end
        send_row(a, 8, 5);
        check_emit(a, 8, 5, 1'b1, b);
        check_emit(b, 8, 5, 1'b0, z);

        // sweep: all degrees, many patterns and thresholds
        for (int d = 1; d <= 8; d++) begin
            for (int t = 0; t < 40; t++) begin
                for (int k = 0; k < 8; k++) begin
                    a[k] = (t % 3 == 0) ? ((rnd() & 32) | (8 + (rnd() & 3))) : rnd();
                end
                run_row(a, d, (t * 7) % 32);
            end
        end

        finish_up();
    end

endmodule